// File: doc/BRIEF.md
# Packed Dot-Product Accumulate Unit

This block is a pipelined integer datapath that adds small dot products into a packed vector of 32-bit running sums. Three packed operands arrive together: an accumulator vector and two source vectors. Each 32-bit lane of the result is the accumulator lane plus the sum of the products taken from the matching 32-bit lane of the two sources. A 2-bit operation code selects the product form and whether the final add saturates. The product form is either four byte products, with unsigned bytes from the first source and signed bytes from the second, or two signed halfword products.

Each result lane then passes through a write mask that has one bit per lane. A lane whose mask bit is clear either keeps the accumulator value (merge) or becomes zero (zeroing), as one mode input selects. The active vector width is a parameter of 128 or 256 bits. The port width is fixed at the widest setting, and result lanes above the active width read as zero. Results appear two clock cycles after the inputs, together with a valid flag.

Top module: `dotacc_unit`

## Requirements
- R1: With op = 2'b00, each active result lane j is (acc lane j + sum over k=0..3 of zero-extended byte 4j+k of `a_in` times sign-extended byte 4j+k of `b_in`), taken modulo 2^32. Byte 4j+k sits at bits [32j+8k+7 : 32j+8k].
- R2: With op = 2'b10, each active result lane j is (acc lane j + signed halfword 2j+h of `a_in` times signed halfword 2j+h of `b_in`, summed over h=0..1), taken modulo 2^32. Halfword 2j+h sits at bits [32j+16h+15 : 32j+16h].
- R3: The non-saturating codes (op[0] = 0) wrap. For example, 0x7FFFFFFF + 1 + 1 + 1 + 1 gives 0x80000003.
- R4: The saturating codes (op = 2'b01 byte, op = 2'b11 halfword) compute the exact lane sum and clamp it to [0x80000000, 0x7FFFFFFF] read as signed.
- R5: A lane whose `lane_mask` bit is 1 receives the computed value of R1, R2 or R4.
- R6: A lane whose `lane_mask` bit is 0 while `zero_mode` is 0 receives the accumulator lane unchanged.
- R7: A lane whose `lane_mask` bit is 0 while `zero_mode` is 1 receives zero.
- R8: Result lanes at or above VEC_W/32 are always zero. Input bits above VEC_W, and the mask bits above VEC_W/32, have no effect.
- R9: `out_valid` is high exactly two rising edges after an edge that samples `in_valid` high. `result` belongs to those sampled inputs.
- R10: A rising edge with `rst_n` low clears both pipeline stages, so `out_valid` is 0 after that edge.
- R11: In halfword mode, both products (-32768)×(-32768) added to an accumulator of 0x7FFFFFFF give 0x7FFFFFFF with saturation and 0xFFFFFFFF without it.
- R12: In byte mode, all A bytes 0xFF and all B bytes 0x80 with an accumulator of 0 give 0xFFFE0200 (four products of -32640) in both the saturating and the wrapping variant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Operands on the inputs are to be processed |
| op | input | 2 | 00 byte wrap, 01 byte saturate, 10 halfword wrap, 11 halfword saturate |
| zero_mode | input | 1 | 1: masked-off lanes become zero; 0: they keep the accumulator |
| lane_mask | input | MAX_W/32 | Per-lane write enable |
| acc_in | input | MAX_W | Packed 32-bit accumulator lanes |
| a_in | input | MAX_W | First source (unsigned bytes or signed halfwords) |
| b_in | input | MAX_W | Second source (signed bytes or signed halfwords) |
| out_valid | output | 1 | `result` holds a new value |
| result | output | MAX_W | Packed 32-bit result lanes |

## Verification
The bench builds the unit with VEC_W = 128 and MAX_W = 256. In this configuration four lanes are live and four lanes must stay zero, so every transfer also tests the upper-lane rule and the ignored upper inputs. With this small width, one byte pair of lane 0 can be swept through all 65,536 combinations while the operation code, mask, mode and valid gaps rotate. Directed and biased-random vectors push accumulator and halfword extremes into both clamp limits and both wrap directions.

// File: rtl/dotacc_pkg.sv
package dotacc_pkg;

    localparam int LANE_W    = 32;
    localparam int TERMS     = 4;
    localparam int BYTE_W    = 8;
    localparam int HALF_W    = 16;
    localparam int GUARD     = 3;
    localparam int SUM_W     = LANE_W + GUARD;

    typedef enum logic [1:0] {
        OP_BYTE_WRAP = 2'b00,
        OP_BYTE_SAT  = 2'b01,
        OP_HALF_WRAP = 2'b10,
        OP_HALF_SAT  = 2'b11
    } dot_op_e;

    // Clamp a wide signed sum into the signed 32-bit range.
    function automatic logic [LANE_W-1:0] clamp_lane(input logic [SUM_W-1:0] v);
        logic fits;
        fits = (v[SUM_W-1:LANE_W-1] == '0) || (v[SUM_W-1:LANE_W-1] == '1);
        if (fits)
            return v[LANE_W-1:0];
        else if (v[SUM_W-1])
            return {1'b1, {(LANE_W-1){1'b0}}};
        else
            return {1'b0, {(LANE_W-1){1'b1}}};
    endfunction

endpackage

// File: rtl/dotacc_mul.sv
module dotacc_mul
    import dotacc_pkg::*;
(
    input  logic [LANE_W-1:0]             a_word,
    input  logic [LANE_W-1:0]             b_word,
    input  logic                          half_mode,
    output logic [TERMS-1:0][LANE_W-1:0]  prods
);

    logic [TERMS-1:0][LANE_W-1:0] byte_p;
    logic [TERMS-1:0][LANE_W-1:0] half_p;

    // Unsigned byte of A times signed byte of B: 9x9 signed, 18-bit product.
    always_comb begin
        for (int k = 0; k < TERMS; k++) begin
            logic signed [BYTE_W:0]     ua;
            logic signed [BYTE_W:0]     sb;
            logic signed [2*BYTE_W+1:0] pp;
            ua = {1'b0, a_word[k*BYTE_W +: BYTE_W]};
            sb = {b_word[k*BYTE_W+BYTE_W-1], b_word[k*BYTE_W +: BYTE_W]};
            pp = ua * sb;
            byte_p[k] = {{(LANE_W-2*BYTE_W-2){pp[2*BYTE_W+1]}}, pp};
        end
    end

    // Signed halfword products; upper two terms unused in this mode.
    always_comb begin
        half_p = '0;
        for (int h = 0; h < 2; h++) begin
            logic signed [HALF_W-1:0] ha;
            logic signed [HALF_W-1:0] hb;
            logic signed [LANE_W-1:0] hp;
            ha = a_word[h*HALF_W +: HALF_W];
            hb = b_word[h*HALF_W +: HALF_W];
            hp = ha * hb;
            half_p[h] = hp;
        end
    end

    assign prods = half_mode ? half_p : byte_p;

endmodule

// File: rtl/dotacc_reduce.sv
module dotacc_reduce
    import dotacc_pkg::*;
(
    input  logic [LANE_W-1:0]             acc_word,
    input  logic [TERMS-1:0][LANE_W-1:0]  prods,
    input  logic                          sat_en,
    input  logic                          keep,
    input  logic                          zero_mode,
    output logic [LANE_W-1:0]             lane_out
);

    logic [SUM_W-1:0]  total;
    logic [LANE_W-1:0] computed;

    // Sum at SUM_W bits so that no term overflow is lost before clamping.
    always_comb begin
        total = {{GUARD{acc_word[LANE_W-1]}}, acc_word};
        for (int k = 0; k < TERMS; k++)
            total = total + {{GUARD{prods[k][LANE_W-1]}}, prods[k]};
        computed = sat_en ? clamp_lane(total) : total[LANE_W-1:0];
        if (keep)
            lane_out = computed;
        else if (zero_mode)
            lane_out = '0;
        else
            lane_out = acc_word;
    end

endmodule

// File: rtl/dotacc_unit.sv
module dotacc_unit
    import dotacc_pkg::*;
#(
    parameter int VEC_W = 256,
    parameter int MAX_W = 256
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [1:0]              op,
    input  logic                    zero_mode,
    input  logic [MAX_W/32-1:0]     lane_mask,
    input  logic [MAX_W-1:0]        acc_in,
    input  logic [MAX_W-1:0]        a_in,
    input  logic [MAX_W-1:0]        b_in,
    output logic                    out_valid,
    output logic [MAX_W-1:0]        result
);

    localparam int LANES     = VEC_W / LANE_W;
    localparam int MAX_LANES = MAX_W / LANE_W;

    typedef struct packed {
        logic                                  valid;
        logic                                  sat;
        logic                                  zmode;
        logic [LANES-1:0]                      mask;
        logic [LANES-1:0][LANE_W-1:0]          acc;
        logic [LANES-1:0][TERMS-1:0][LANE_W-1:0] prod;
    } stage1_t;

    typedef struct packed {
        logic                         valid;
        logic [LANES-1:0][LANE_W-1:0] res;
    } stage2_t;

    typedef struct packed {
        stage1_t s1;
        stage2_t s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [LANES-1:0][TERMS-1:0][LANE_W-1:0] prod_w;
    logic [LANES-1:0][LANE_W-1:0]            red_w;

    dot_op_e op_e;
    assign op_e = dot_op_e'(op);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dotacc_mul u_mul (
            .a_word    (a_in[g*LANE_W +: LANE_W]),
            .b_word    (b_in[g*LANE_W +: LANE_W]),
            .half_mode (op_e inside {OP_HALF_WRAP, OP_HALF_SAT}),
            .prods     (prod_w[g])
        );
        dotacc_reduce u_red (
            .acc_word  (pipe_q.s1.acc[g]),
            .prods     (pipe_q.s1.prod[g]),
            .sat_en    (pipe_q.s1.sat),
            .keep      (pipe_q.s1.mask[g]),
            .zero_mode (pipe_q.s1.zmode),
            .lane_out  (red_w[g])
        );
    end

    if (LANES < MAX_LANES) begin : g_hi_inputs
        logic unused_hi;
        assign unused_hi = ^{acc_in[MAX_W-1:VEC_W], a_in[MAX_W-1:VEC_W],
                             b_in[MAX_W-1:VEC_W], lane_mask[MAX_LANES-1:LANES]};
    end

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1.valid = in_valid;
        if (in_valid) begin
            pipe_d.s1.sat   = (op_e == OP_BYTE_SAT) || (op_e == OP_HALF_SAT);
            pipe_d.s1.zmode = zero_mode;
            pipe_d.s1.mask  = lane_mask[LANES-1:0];
            pipe_d.s1.acc   = acc_in[VEC_W-1:0];
            pipe_d.s1.prod  = prod_w;
        end
        pipe_d.s2.valid = pipe_q.s1.valid;
        if (pipe_q.s1.valid)
            pipe_d.s2.res = red_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            pipe_q <= '0;
        else
            pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s2.valid;

    for (genvar l = 0; l < MAX_LANES; l++) begin : g_out
        if (l < LANES) begin : g_live
            assign result[l*LANE_W +: LANE_W] = pipe_q.s2.res[l];
        end else begin : g_dead
            assign result[l*LANE_W +: LANE_W] = '0;
        end
    end

endmodule

// File: rtl/dotacc_chk.sv
module dotacc_chk #(
    parameter int VEC_W = 256,
    parameter int MAX_W = 256
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic                zero_mode,
    input logic [MAX_W/32-1:0] lane_mask,
    input logic [MAX_W-1:0]    acc_in,
    input logic                out_valid,
    input logic [MAX_W-1:0]    result
);

    localparam int LANES = VEC_W / 32;

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= 2'd0;
        else if (since_rst != 2'd2)
            since_rst <= since_rst + 2'd1;
    end

    // R9
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
        // R7
        zero_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd2 && out_valid && $past(zero_mode, 2) && !$past(lane_mask[i], 2))
            |-> (result[i*32 +: 32] == 32'd0));

        // R6
        merge_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd2 && out_valid && !$past(zero_mode, 2) && !$past(lane_mask[i], 2))
            |-> (result[i*32 +: 32] == $past(acc_in[i*32 +: 32], 2)));
    end

endmodule

bind dotacc_unit dotacc_chk #(.VEC_W(VEC_W), .MAX_W(MAX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .zero_mode (zero_mode),
    .lane_mask (lane_mask),
    .acc_in    (acc_in),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/dotacc_unit_test.sv
module dotacc_unit_test;

    localparam int VW = 128;
    localparam int MW = 256;
    localparam int NL = VW / 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [1:0]     op = 2'b00;
    logic           zero_mode = 1'b0;
    logic [7:0]     lane_mask = '0;
    logic [MW-1:0]  acc_in = '0;
    logic [MW-1:0]  a_in = '0;
    logic [MW-1:0]  b_in = '0;
    logic           out_valid;
    logic [MW-1:0]  result;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        logic          v;
        logic [MW-1:0] exp;
        logic [7:0]    mask;
        logic          zm;
        logic [1:0]    op;
        string         tag;
    } rec_t;

    rec_t hq[$];

    always #2 clk = ~clk;

    dotacc_unit #(.VEC_W(VW), .MAX_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .zero_mode(zero_mode), .lane_mask(lane_mask), .acc_in(acc_in),
        .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .result(result)
    );

    function automatic logic [MW-1:0] rand_vec();
        logic [MW-1:0] v;
        for (int w = 0; w < MW/32; w++) v[w*32 +: 32] = $urandom;
        return v;
    endfunction

    // Arithmetic model from the requirements.
    function automatic logic [MW-1:0] model(input logic [1:0] o, input logic zm,
            input logic [7:0] m, input logic [MW-1:0] acc, input logic [MW-1:0] a,
            input logic [MW-1:0] b);
        logic [MW-1:0] r = '0;
        for (int j = 0; j < NL; j++) begin
            longint s = longint'($signed(acc[32*j +: 32]));
            logic [31:0] lane;
            if (!o[1]) begin
                for (int k = 0; k < 4; k++)
                    s += longint'(a[32*j+8*k +: 8]) * longint'($signed(b[32*j+8*k +: 8]));
            end else begin
                for (int h = 0; h < 2; h++)
                    s += longint'($signed(a[32*j+16*h +: 16])) * longint'($signed(b[32*j+16*h +: 16]));
            end
            if (o[0]) begin
                if (s > 64'sd2147483647) s = 64'sd2147483647;
                if (s < -64'sd2147483648) s = -64'sd2147483648;
            end
            lane = s[31:0];
            if (m[j]) r[32*j +: 32] = lane;
            else if (zm) r[32*j +: 32] = 32'd0;
            else r[32*j +: 32] = acc[32*j +: 32];
        end
        return r;
    endfunction

    function automatic string lane_tag(input rec_t r, input int j);
        if (r.tag != "") return r.tag;
        if (j >= NL) return "R8";
        if (!r.mask[j]) return r.zm ? "R7" : "R6";
        case (r.op)
            2'b00:   return "R5/R1";
            2'b10:   return "R5/R2";
            default: return "R5/R4";
        endcase
    endfunction

    task automatic check_out(input rec_t r);
        n_chk++;
        if (out_valid !== r.v) begin
            n_fail++;
            $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, r.v);
        end
        if (r.v) begin
            for (int j = 0; j < MW/32; j++) begin
                n_chk++;
                if (result[32*j +: 32] !== r.exp[32*j +: 32]) begin
                    n_fail++;
                    $display("FAIL %s lane %0d actual=%h expected=%h",
                             lane_tag(r, j), j, result[32*j +: 32], r.exp[32*j +: 32]);
                end
            end
        end
    endtask

    // Called at a falling edge: check what is due, drive next, wait a cycle.
    task automatic cycle(input logic v, input logic [1:0] o, input logic zm,
            input logic [7:0] m, input logic [MW-1:0] acc, input logic [MW-1:0] a,
            input logic [MW-1:0] b, input string tag);
        rec_t r;
        check_out(hq.pop_front());
        in_valid = v; op = o; zero_mode = zm; lane_mask = m;
        acc_in = acc; a_in = a; b_in = b;
        r.v = v; r.op = o; r.zm = zm; r.mask = m; r.tag = tag;
        r.exp = model(o, zm, m, acc, a, b);
        hq.push_back(r);
        @(negedge clk);
    endtask

    function automatic logic [MW-1:0] fill(input logic [31:0] w);
        return {(MW/32){w}};
    endfunction

    function automatic logic [15:0] pick_half();
        case ($urandom % 5)
            0: return 16'h8000;
            1: return 16'h7FFF;
            2: return 16'hFFFF;
            3: return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    function automatic logic [31:0] pick_acc();
        case ($urandom % 4)
            0: return 32'h7FFFFFFF;
            1: return 32'h80000000;
            2: return 32'h7FFF0000 + 32'($urandom % 65536);
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        rec_t idle;
        idle.v = 1'b0; idle.exp = '0; idle.mask = '0; idle.zm = 1'b0;
        idle.op = 2'b00; idle.tag = "";

        // R10: out_valid stays low while reset is applied, even with in_valid high
        in_valid = 1'b1;
        acc_in = rand_vec(); a_in = rand_vec(); b_in = rand_vec();
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            n_chk++;
            if (out_valid !== 1'b0) begin
                n_fail++;
                $display("FAIL R10 out_valid actual=%0b expected=0", out_valid);
            end
            @(negedge clk);
        end
        rst_n = 1'b1;
        hq.push_back(idle);
        hq.push_back(idle);

        // R11: halfword extreme products with accumulator at the top
        cycle(1'b1, 2'b11, 1'b0, 8'hFF, fill(32'h7FFFFFFF), fill(32'h80008000), fill(32'h80008000), "R11");
        cycle(1'b1, 2'b10, 1'b0, 8'hFF, fill(32'h7FFFFFFF), fill(32'h80008000), fill(32'h80008000), "R11");
        // R12: byte extreme products, both variants
        cycle(1'b1, 2'b00, 1'b0, 8'hFF, '0, fill(32'hFFFFFFFF), fill(32'h80808080), "R12");
        cycle(1'b1, 2'b01, 1'b0, 8'hFF, '0, fill(32'hFFFFFFFF), fill(32'h80808080), "R12");
        // R3: wrap past the top of the range
        cycle(1'b1, 2'b00, 1'b0, 8'hFF, fill(32'h7FFFFFFF), fill(32'h01010101), fill(32'h01010101), "R3");
        // R4: clamp at the bottom, byte saturating
        cycle(1'b1, 2'b01, 1'b0, 8'hFF, fill(32'h80000000), fill(32'hFFFFFFFF), fill(32'h80808080), "R4");
        // R8: upper inputs and mask bits full, upper lanes must read zero
        cycle(1'b1, 2'b00, 1'b1, 8'hF0, fill(32'h12345678), fill(32'hFFFFFFFF), fill(32'h7F7F7F7F), "");
        // R9: a gap between transfers
        cycle(1'b0, 2'b00, 1'b0, 8'h00, rand_vec(), rand_vec(), rand_vec(), "");
        cycle(1'b0, 2'b00, 1'b0, 8'h00, rand_vec(), rand_vec(), rand_vec(), "");

        // Exhaustive sweep of one byte pair in lane 0 (R1, R2, R4, R5, R6, R7)
        for (int i = 0; i < 65536; i++) begin
            logic [MW-1:0] a = rand_vec();
            logic [MW-1:0] b = rand_vec();
            logic [31:0]   i32 = 32'(i);
            a[7:0] = i32[7:0];
            b[7:0] = i32[15:8];
            cycle((i % 11) != 5, i32[1:0] ^ i32[9:8], i32[4], 8'($urandom),
                  rand_vec(), a, b, "");
        end

        // Biased random near the clamp and wrap limits (R2, R3, R4)
        for (int i = 0; i < 3000; i++) begin
            logic [MW-1:0] a;
            logic [MW-1:0] b;
            logic [MW-1:0] acc;
            for (int w = 0; w < MW/16; w++) begin
                a[16*w +: 16] = pick_half();
                b[16*w +: 16] = pick_half();
            end
            for (int w = 0; w < MW/32; w++) acc[32*w +: 32] = pick_acc();
            cycle(1'b1, 2'($urandom), 1'($urandom), 8'($urandom), acc, a, b, "");
        end

        // Drain the pipeline
        cycle(1'b0, 2'b00, 1'b0, 8'h00, '0, '0, '0, "");
        cycle(1'b0, 2'b00, 1'b0, 8'h00, '0, '0, '0, "");
        cycle(1'b0, 2'b00, 1'b0, 8'h00, '0, '0, '0, "");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule